// File: doc/BRIEF.md
# Dual BCD Alarm Comparator with Wake and Power-Off Output

This block watches a BCD calendar time supplied by a separate time counter and compares it against two independently programmed alarm settings. Each alarm holds six 8-bit BCD fields: seconds, minutes, hours, day, month and year. The comparison happens only in the cycle in which the counter signals a new second. A hit requires all six fields to be equal, and no field can be masked.

A hit on the first alarm sets a sticky status flag. That flag can raise the alarm interrupt and, through a separate wake-enable register, a wake request. A hit on the second alarm sets its own flag. When the power-control bit is armed, the hit also pulls the active-high power-enable output low so that an off-chip power controller removes supply. The pin then stays low until reset.

Software reaches the block through a plain register port. A write takes effect at the clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`. This port is a control path and has no handshake.

Top module: `rtc_dual_alarm`

## Requirements
- R1: Alarm 1 fields are 8-bit read/write registers, at offsets 0x20 (seconds), 0x24 (minutes), 0x28 (hours), 0x2C (day), 0x30 (month) and 0x34 (year). A read returns the field in bits 7:0 and zeros above.
- R2: Alarm 2 fields use the same layout at offsets 0x80, 0x84, 0x88, 0x8C, 0x90 and 0x94.
- R3: An alarm fires only in a cycle where `tick` is high and all six time inputs equal that alarm's six fields. A mismatch in any single field, or no `tick`, gives no hit.
- R4: Register 0x44 holds the status flags: bit 6 for alarm 1 and bit 7 for alarm 2. A flag sets on the edge after its alarm fires. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged. When a clear and a new hit fall in the same cycle, the flag stays set.
- R5: Register 0x48 holds the enables: bit 3 for alarm 1 and bit 4 for alarm 2. `alarm_irq` is high exactly when some status flag is set together with its enable.
- R6: In register 0x7C, bit 1 enables wake. `wake_req` is high exactly when the alarm 1 flag and that bit are both set.
- R7: In register 0x98, bit 16 arms the power-off. `pwr_en` is 1 out of reset. It falls to 0 on the edge after alarm 2 fires while bit 16 is set, and it stays 0 until reset, whatever is written afterwards.
- R8: After reset, every register reads 0, `alarm_irq` and `wake_req` are 0, and `pwr_en` is 1.
- R9: A write to an unmapped offset changes no state, and a read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe marking a new second |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_day | input | 8 | Current day, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 8 | Current year, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| alarm_irq | output | 1 | Alarm interrupt |
| wake_req | output | 1 | Wake request |
| pwr_en | output | 1 | Power enable; 0 requests power-off |

## Verification
Two functions can fall in the same cycle: a software write-one-to-clear of a status flag, and a fresh alarm hit on that same flag. The bench provokes this by holding a matching time and raising `tick` and `reg_wr` together in one cycle, with the clear bit set in the write data. It then reads the status register on the following cycle and expects the flag still set. A second bench step clears the flag with `tick` low and confirms the clear works when no hit competes with it.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NF = 6;
  localparam int FW = 8;
  localparam int NALM = 2;
  localparam int TW = NF * FW;

  localparam logic [AW-1:0] OFS_ALM1 = 8'h20;
  localparam logic [AW-1:0] OFS_ALM2 = 8'h80;
  localparam logic [AW-1:0] OFS_STAT = 8'h44;
  localparam logic [AW-1:0] OFS_IEN  = 8'h48;
  localparam logic [AW-1:0] OFS_WAKE = 8'h7C;
  localparam logic [AW-1:0] OFS_PWR  = 8'h98;

  localparam int STAT_LSB  = 6;
  localparam int IEN_LSB   = 3;
  localparam int WAKE_BIT  = 1;
  localparam int PWR_BIT   = 16;
  localparam int FIELD_STRIDE = 4;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_alm_pkg::*;
#(
  parameter logic [AW-1:0] BASE = OFS_ALM1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [FW-1:0] wdata,
  input  logic [TW-1:0] now,
  output logic [TW-1:0] fields,
  output logic          hit
);
  logic [NF-1:0] eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields <= '0;
    end else if (wr) begin
      for (int f = 0; f < NF; f++) begin
        if (addr == AW'(BASE + FIELD_STRIDE * f)) fields[f*FW +: FW] <= wdata;
      end
    end
  end

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign eq[g] = (now[g*FW +: FW] == fields[g*FW +: FW]);
  end

  assign hit = &eq;
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import rtc_alm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NALM-1:0] fire,
  output logic [NALM-1:0] st,
  output logic [NALM-1:0] ien,
  output logic            wake_en,
  output logic            pwr_arm,
  output logic            irq,
  output logic            wake,
  output logic            pwr_en
);
  logic [NALM-1:0] clr;
  logic            pwr_off;

  assign clr = (wr && addr == OFS_STAT) ? wdata[STAT_LSB +: NALM] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= '0;
      ien     <= '0;
      wake_en <= 1'b0;
      pwr_arm <= 1'b0;
      pwr_off <= 1'b0;
    end else begin
      st <= (st & ~clr) | fire;
      if (wr && addr == OFS_IEN)  ien     <= wdata[IEN_LSB +: NALM];
      if (wr && addr == OFS_WAKE) wake_en <= wdata[WAKE_BIT];
      if (wr && addr == OFS_PWR)  pwr_arm <= wdata[PWR_BIT];
      if (fire[1] && pwr_arm)     pwr_off <= 1'b1;
    end
  end

  assign irq    = |(st & ien);
  assign wake   = st[0] & wake_en;
  assign pwr_en = ~pwr_off;

  p_set_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire[0] |=> st[0]);
  p_clear_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[0] && !fire[0]) |=> !st[0]);
  p_rise_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st[1]) |-> $past(fire[1]));
  p_pwr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !pwr_en);
  p_pwr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(fire[1] && pwr_arm));
endmodule

// File: rtl/rtc_dual_alarm.sv
module rtc_dual_alarm
  import rtc_alm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [7:0]    now_sec,
  input  logic [7:0]    now_min,
  input  logic [7:0]    now_hour,
  input  logic [7:0]    now_day,
  input  logic [7:0]    now_mon,
  input  logic [7:0]    now_year,
  input  logic          reg_wr,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          alarm_irq,
  output logic          wake_req,
  output logic          pwr_en
);
  localparam logic [AW-1:0] BASES [NALM] = '{OFS_ALM1, OFS_ALM2};

  logic [TW-1:0]   now;
  logic [TW-1:0]   fld [NALM];
  logic [NALM-1:0] hit;
  logic [NALM-1:0] fire;
  logic [NALM-1:0] st, ien;
  logic            wake_en, pwr_arm;

  assign now = {now_year, now_mon, now_day, now_hour, now_min, now_sec};

  for (genvar a = 0; a < NALM; a++) begin : g_alm
    alarm_match #(.BASE(BASES[a])) u_match (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata[FW-1:0]), .now(now), .fields(fld[a]), .hit(hit[a])
    );
  end

  assign fire = tick ? hit : '0;

  alarm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .fire(fire), .st(st), .ien(ien), .wake_en(wake_en), .pwr_arm(pwr_arm),
    .irq(alarm_irq), .wake(wake_req), .pwr_en(pwr_en)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_STAT: reg_rdata[STAT_LSB +: NALM] = st;
      OFS_IEN:  reg_rdata[IEN_LSB +: NALM]  = ien;
      OFS_WAKE: reg_rdata[WAKE_BIT]         = wake_en;
      OFS_PWR:  reg_rdata[PWR_BIT]          = pwr_arm;
      default:  reg_rdata = '0;
    endcase
    for (int a = 0; a < NALM; a++) begin
      for (int f = 0; f < NF; f++) begin
        if (reg_addr == AW'(BASES[a] + FIELD_STRIDE * f))
          reg_rdata = DW'(fld[a][f*FW +: FW]);
      end
    end
  end
endmodule

// File: tb/tb_rtc_dual_alarm.sv
`timescale 1ns/1ps
module tb_rtc_dual_alarm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00;
  logic [7:0] now_day = 8'h01, now_mon = 8'h01, now_year = 8'h00;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic alarm_irq, wake_req, pwr_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_dual_alarm dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .now_mon(now_mon), .now_year(now_year),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_irq(alarm_irq), .wake_req(wake_req), .pwr_en(pwr_en)
  );

  logic [7:0] a1 [6] = '{8'h30, 8'h15, 8'h09, 8'h21, 8'h06, 8'h24};
  logic [7:0] a2 [6] = '{8'h05, 8'h00, 8'h23, 8'h31, 8'h12, 8'h99};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic set_time(logic [7:0] t [6]);
    now_sec = t[0]; now_min = t[1]; now_hour = t[2];
    now_day = t[3]; now_mon = t[4]; now_year = t[5];
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    rd(8'h44, d); chk("R8 status", d, 0);
    rd(8'h98, d); chk("R8 pwr ctl", d, 0);
    rd(8'h20, d); chk("R8 alarm1 sec", d, 0);
    chk("R8 irq", alarm_irq, 0); chk("R8 wake", wake_req, 0); chk("R8 pwr_en", pwr_en, 1);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    for (int f = 0; f < 6; f++) begin
      wr(8'(8'h20 + 4*f), {24'hABCDEF, a1[f]});
      wr(8'(8'h80 + 4*f), {24'h123456, a2[f]});
    end
    for (int f = 0; f < 6; f++) begin
      rd(8'(8'h20 + 4*f), d); chk("R1 alarm1 field", d, {24'h0, a1[f]});
      rd(8'(8'h80 + 4*f), d); chk("R2 alarm2 field", d, {24'h0, a2[f]});
    end
  endtask

  task automatic t_match1();
    logic [31:0] d;
    logic [7:0] t [6];
    t = a1; t[5] = 8'h25; set_time(t); pulse_tick();
    rd(8'h44, d); chk("R3 year mismatch", d, 0);
    t = a1; t[0] = 8'h31; set_time(t); pulse_tick();
    rd(8'h44, d); chk("R3 seconds mismatch", d, 0);
    set_time(a1); repeat (3) @(negedge clk);
    rd(8'h44, d); chk("R3 no tick", d, 0);
    pulse_tick();
    rd(8'h44, d); chk("R4 alarm1 flag", d, 32'h40);
    chk("R5 irq disabled", alarm_irq, 0); chk("R6 wake disabled", wake_req, 0);
    wr(8'h48, 32'h08); chk("R5 irq alarm1", alarm_irq, 1);
    wr(8'h7C, 32'h02); chk("R6 wake", wake_req, 1);
    rd(8'h7C, d); chk("R6 wake readback", d, 32'h02);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(8'h44, 32'h0); rd(8'h44, d); chk("R4 write zero", d, 32'h40);
    // clear and a new hit in one cycle: flag must remain set
    @(negedge clk); tick = 1'b1; reg_wr = 1'b1; reg_addr = 8'h44; reg_wdata = 32'h40;
    @(negedge clk); tick = 1'b0; reg_wr = 1'b0; reg_wdata = 32'h0;
    rd(8'h44, d); chk("R4 set wins", d, 32'h40);
    wr(8'h44, 32'h40); rd(8'h44, d); chk("R4 w1c", d, 0);
    chk("R5 irq after clear", alarm_irq, 0); chk("R6 wake after clear", wake_req, 0);
  endtask

  task automatic t_alarm2();
    logic [31:0] d;
    set_time(a2); pulse_tick();
    rd(8'h44, d); chk("R4 alarm2 flag", d, 32'h80);
    chk("R7 pwr not armed", pwr_en, 1);
    chk("R5 irq alarm2 disabled", alarm_irq, 0);
    wr(8'h48, 32'h18); chk("R5 irq alarm2", alarm_irq, 1);
    chk("R6 wake ignores alarm2", wake_req, 0);
    wr(8'h44, 32'h80);
    wr(8'h98, 32'h0001_0000); rd(8'h98, d); chk("R7 arm readback", d, 32'h0001_0000);
    chk("R7 armed no hit", pwr_en, 1);
    pulse_tick(); chk("R7 pwr off", pwr_en, 0);
    wr(8'h44, 32'h80); wr(8'h98, 32'h0); repeat (2) @(negedge clk);
    chk("R7 stays off", pwr_en, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h60, 32'hFFFF_FFFF); rd(8'h60, d); chk("R9 unmapped read", d, 0);
    rd(8'h44, d); chk("R9 status untouched", d, 0);
    rd(8'h48, d); chk("R9 enables untouched", d, 32'h18);
    do_reset(); chk("R7 reset restores pwr", pwr_en, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_fields();
    t_match1();
    t_clear();
    t_alarm2();
    t_unmapped();
    finish_run();
  end
endmodule